// File: doc/BRIEF.md
# Rectangle Transfer Path Selector

This block decides which of four copy engines should move a rectangle of pixels from one surface to another. It looks at a source and a destination surface descriptor and at one feature input, and it produces a one-hot choice with no clock. Each descriptor carries pitch (zero means a swizzled layout), width, height, depth, bytes per pixel and the corners of the rectangle to move. The destination descriptor also carries its base offset and a flag that says it sits in video memory. The feature input says whether the newer 3D engine class is present.

There are four candidates: a line-by-line pitched copier, a scaling image engine, a 3D textured-quad blit, and a per-pixel copy loop. Each one has its own eligibility rules. These rules cover alignment, pitch, size limits and scaling. The candidates are tried in a fixed priority, and the first eligible one is selected. The block also reports whether the source and destination spans differ. When no candidate qualifies, it raises a flag so the caller can reject the request. The block only makes the choice; it does not start or perform any copy.

Top module: `xferPathSelect`

## Requirements
- R1: `isScaled` is 1 exactly when (srcX1-srcX0) differs from (dstX1-dstX0), or (srcY1-srcY0) differs from (dstY1-dstY0). Differences are taken modulo 2^16. The positions of the corners do not matter, only the spans.
- R2: `methodSel` has at most one bit set. The bits are: 0 = pitched copy, 1 = scaling image engine, 2 = 3D blit, 3 = per-pixel copy. The set bit is the lowest-numbered eligible candidate.
- R3: The pitched copy (bit 0) is eligible only when both pitches are nonzero and `isScaled` is 0.
- R4: The scaling engine (bit 1) needs all of the following: a nonzero source pitch; source width and height each at least 2; the bitwise OR of source width and height no greater than 1024; and both depths at most 1.
- R5: The scaling engine (bit 1) also needs the destination offset to be a multiple of 64.
- R6: For the scaling engine with destination pitch 0, the destination width and height must each be at least 2. The bitwise OR of destination width and height must also be no greater than 2048.
- R7: For the scaling engine with a nonzero destination pitch, `dstInVram` must be 1 and the destination pitch must be a multiple of 64.
- R8: The 3D blit (bit 2) needs all of the following: `hasNewEngine` = 1; destination offset and pitch both multiples of 64; destination depth at most 1; destination width and height each at least 2.
- R9: The 3D blit is ineligible in either of these cases: either bytes-per-pixel value is above 4; or the destination has 1 byte per pixel together with pitch 0.
- R10: The per-pixel copy (bit 3) is eligible exactly when `isScaled` is 0.
- R11: When no candidate is eligible, `noMethod` is 1 and `methodSel` is 0. Otherwise `noMethod` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| srcPitch | input | 16 | Source bytes per row, 0 = swizzled |
| srcWidth | input | 16 | Source surface width |
| srcHeight | input | 16 | Source surface height |
| srcDepth | input | 12 | Source surface depth |
| srcBpp | input | 3 | Source bytes per pixel |
| srcX0 | input | 16 | Source rectangle left |
| srcX1 | input | 16 | Source rectangle right (exclusive) |
| srcY0 | input | 16 | Source rectangle top |
| srcY1 | input | 16 | Source rectangle bottom (exclusive) |
| dstOffset | input | 32 | Destination base byte offset |
| dstPitch | input | 16 | Destination bytes per row, 0 = swizzled |
| dstWidth | input | 16 | Destination surface width |
| dstHeight | input | 16 | Destination surface height |
| dstDepth | input | 12 | Destination surface depth |
| dstBpp | input | 3 | Destination bytes per pixel |
| dstX0 | input | 16 | Destination rectangle left |
| dstX1 | input | 16 | Destination rectangle right (exclusive) |
| dstY0 | input | 16 | Destination rectangle top |
| dstY1 | input | 16 | Destination rectangle bottom (exclusive) |
| dstInVram | input | 1 | Destination resides in video memory |
| hasNewEngine | input | 1 | Newer 3D engine class available |
| methodSel | output | 4 | One-hot chosen engine |
| noMethod | output | 1 | No engine qualifies |
| isScaled | output | 1 | Source and destination spans differ |

## Verification
The bench starts from a pitched, unscaled, well-aligned pair of surfaces. From there it changes one field at a time, so each vector sends the choice down to a specific next engine or to none. This shows which single rule removed the higher-priority candidate.

Some vectors make the transfer scaled, which separates the scaling engine from the blit and from the rejection case. Others clear the source pitch, drop the new engine, or misalign the destination offset or pitch, each of which removes one candidate.

Size corners use bitwise-OR pairs: 1024|512 and 4096|2 are rejected, while 1024|1024 is accepted. The byte-per-pixel and depth limits are also probed. Moved corners with equal spans confirm that only the spans, not the positions, set the scaled flag.

// File: rtl/xferPathPkg.sv
package xferPathPkg;

  localparam int METHOD_COUNT = 4;
  localparam int M_PITCHED  = 0;
  localparam int M_SCALER   = 1;
  localparam int M_BLIT3D   = 2;
  localparam int M_PERPIXEL = 3;

  // Condition strobes handed from the geometry datapath to the decision logic
  typedef struct packed {
    logic scaled;
    logic srcPitchNz;
    logic dstPitchNz;
    logic srcDimOk;
    logic depthsFlat;
    logic dstOfsAligned;
    logic dstPitchAligned;
    logic dstSwzDimOk;
    logic dstInVram;
    logic dstDepthFlat;
    logic dstMinDimOk;
    logic bppInRange;
    logic dstBytePitchless;
  } xferFlags_t;

endpackage

// File: rtl/xferGeom.sv
module xferGeom
  import xferPathPkg::*;
#(
  parameter int OFS_W       = 32,
  parameter int PITCH_W     = 16,
  parameter int DIM_W       = 16,
  parameter int CRD_W       = 16,
  parameter int DEPTH_W     = 12,
  parameter int BPP_W       = 3,
  parameter int ALIGN_LOG2  = 6,
  parameter int SRC_DIM_MAX = 1024,
  parameter int DST_DIM_MAX = 2048,
  parameter int MIN_DIM     = 2,
  parameter int MAX_BPP     = 4
) (
  input  logic [PITCH_W-1:0] srcPitch,
  input  logic [DIM_W-1:0]   srcWidth,
  input  logic [DIM_W-1:0]   srcHeight,
  input  logic [DEPTH_W-1:0] srcDepth,
  input  logic [BPP_W-1:0]   srcBpp,
  input  logic [CRD_W-1:0]   srcX0,
  input  logic [CRD_W-1:0]   srcX1,
  input  logic [CRD_W-1:0]   srcY0,
  input  logic [CRD_W-1:0]   srcY1,
  input  logic [OFS_W-1:0]   dstOffset,
  input  logic [PITCH_W-1:0] dstPitch,
  input  logic [DIM_W-1:0]   dstWidth,
  input  logic [DIM_W-1:0]   dstHeight,
  input  logic [DEPTH_W-1:0] dstDepth,
  input  logic [BPP_W-1:0]   dstBpp,
  input  logic [CRD_W-1:0]   dstX0,
  input  logic [CRD_W-1:0]   dstX1,
  input  logic [CRD_W-1:0]   dstY0,
  input  logic [CRD_W-1:0]   dstY1,
  input  logic               dstInVram,
  output xferFlags_t         flags
);

  localparam logic [DIM_W-1:0]   SRC_LIM   = DIM_W'(SRC_DIM_MAX);
  localparam logic [DIM_W-1:0]   DST_LIM   = DIM_W'(DST_DIM_MAX);
  localparam logic [DIM_W-1:0]   DIM_FLOOR = DIM_W'(MIN_DIM);
  localparam logic [BPP_W-1:0]   BPP_LIM   = BPP_W'(MAX_BPP);
  localparam logic [BPP_W-1:0]   BPP_ONE   = BPP_W'(1);
  localparam logic [DEPTH_W-1:0] DEPTH_ONE = DEPTH_W'(1);

  logic [CRD_W-1:0] srcSpanX, srcSpanY, dstSpanX, dstSpanY;
  logic [DIM_W-1:0] srcDimOr, dstDimOr;

  always_comb begin
    srcSpanX = srcX1 - srcX0;
    srcSpanY = srcY1 - srcY0;
    dstSpanX = dstX1 - dstX0;
    dstSpanY = dstY1 - dstY0;
    // size limits compare the bitwise OR of both extents, bit-exact
    srcDimOr = srcWidth | srcHeight;
    dstDimOr = dstWidth | dstHeight;
  end

  always_comb begin
    flags.scaled          = (srcSpanX != dstSpanX) || (srcSpanY != dstSpanY);
    flags.srcPitchNz      = |srcPitch;
    flags.dstPitchNz      = |dstPitch;
    flags.srcDimOk        = (srcDimOr <= SRC_LIM) && (srcWidth >= DIM_FLOOR)
                            && (srcHeight >= DIM_FLOOR);
    flags.depthsFlat      = (srcDepth <= DEPTH_ONE) && (dstDepth <= DEPTH_ONE);
    flags.dstOfsAligned   = ~|dstOffset[ALIGN_LOG2-1:0];
    flags.dstPitchAligned = ~|dstPitch[ALIGN_LOG2-1:0];
    flags.dstSwzDimOk     = (dstDimOr <= DST_LIM) && (dstWidth >= DIM_FLOOR)
                            && (dstHeight >= DIM_FLOOR);
    flags.dstInVram       = dstInVram;
    flags.dstDepthFlat    = dstDepth <= DEPTH_ONE;
    flags.dstMinDimOk     = (dstWidth >= DIM_FLOOR) && (dstHeight >= DIM_FLOOR);
    flags.bppInRange      = (srcBpp <= BPP_LIM) && (dstBpp <= BPP_LIM);
    flags.dstBytePitchless = (dstBpp == BPP_ONE) && ~|dstPitch;
  end

endmodule

// File: rtl/xferElig.sv
module xferElig
  import xferPathPkg::*;
(
  input  xferFlags_t              flags,
  input  logic                    hasNewEngine,
  output logic [METHOD_COUNT-1:0] eligible
);

  logic scalerDstOk;

  always_comb begin
    scalerDstOk = flags.dstPitchNz ? (flags.dstInVram && flags.dstPitchAligned)
                                   : flags.dstSwzDimOk;

    eligible[M_PITCHED] = flags.srcPitchNz && flags.dstPitchNz && !flags.scaled;

    eligible[M_SCALER]  = flags.srcPitchNz && flags.srcDimOk && flags.depthsFlat
                          && flags.dstOfsAligned && scalerDstOk;

    eligible[M_BLIT3D]  = hasNewEngine && flags.dstOfsAligned && flags.dstPitchAligned
                          && flags.dstDepthFlat && flags.dstMinDimOk
                          && flags.bppInRange && !flags.dstBytePitchless;

    eligible[M_PERPIXEL] = !flags.scaled;
  end

  // R10: the per-pixel path and the pitched path never serve a scaled move
  always_comb begin
    assert_unscaled_only_R10: assert (!(flags.scaled && (eligible[M_PERPIXEL] || eligible[M_PITCHED])))
      else $error("scaled transfer marked eligible for an unscaled-only path");
  end

endmodule

// File: rtl/xferPick.sv
module xferPick
  import xferPathPkg::*;
(
  input  logic [METHOD_COUNT-1:0] eligible,
  output logic [METHOD_COUNT-1:0] methodSel,
  output logic                    noMethod
);

  logic [METHOD_COUNT:0] taken;

  assign taken[0] = 1'b0;

  for (genvar i = 0; i < METHOD_COUNT; i++) begin : gPrio
    assign methodSel[i] = eligible[i] && !taken[i];
    assign taken[i+1]   = taken[i] || eligible[i];
  end

  assign noMethod = !taken[METHOD_COUNT];

  always_comb begin
    assert_onehot_sel_R2: assert ($onehot0(methodSel))
      else $error("more than one method chosen");
    assert_sel_eligible_R2: assert ((methodSel & ~eligible) == '0)
      else $error("chosen method was not eligible");
    assert_empty_when_none_R11: assert (!noMethod || (methodSel == '0))
      else $error("selection present while no method flagged");
  end

endmodule

// File: rtl/xferPathSelect.sv
module xferPathSelect
  import xferPathPkg::*;
#(
  parameter int OFS_W       = 32,
  parameter int PITCH_W     = 16,
  parameter int DIM_W       = 16,
  parameter int CRD_W       = 16,
  parameter int DEPTH_W     = 12,
  parameter int BPP_W       = 3,
  parameter int ALIGN_LOG2  = 6,
  parameter int SRC_DIM_MAX = 1024,
  parameter int DST_DIM_MAX = 2048,
  parameter int MIN_DIM     = 2,
  parameter int MAX_BPP     = 4
) (
  input  logic [PITCH_W-1:0]      srcPitch,
  input  logic [DIM_W-1:0]        srcWidth,
  input  logic [DIM_W-1:0]        srcHeight,
  input  logic [DEPTH_W-1:0]      srcDepth,
  input  logic [BPP_W-1:0]        srcBpp,
  input  logic [CRD_W-1:0]        srcX0,
  input  logic [CRD_W-1:0]        srcX1,
  input  logic [CRD_W-1:0]        srcY0,
  input  logic [CRD_W-1:0]        srcY1,
  input  logic [OFS_W-1:0]        dstOffset,
  input  logic [PITCH_W-1:0]      dstPitch,
  input  logic [DIM_W-1:0]        dstWidth,
  input  logic [DIM_W-1:0]        dstHeight,
  input  logic [DEPTH_W-1:0]      dstDepth,
  input  logic [BPP_W-1:0]        dstBpp,
  input  logic [CRD_W-1:0]        dstX0,
  input  logic [CRD_W-1:0]        dstX1,
  input  logic [CRD_W-1:0]        dstY0,
  input  logic [CRD_W-1:0]        dstY1,
  input  logic                    dstInVram,
  input  logic                    hasNewEngine,
  output logic [METHOD_COUNT-1:0] methodSel,
  output logic                    noMethod,
  output logic                    isScaled
);

  localparam logic [BPP_W-1:0] BPP_LIM = BPP_W'(MAX_BPP);

  xferFlags_t              flags;
  logic [METHOD_COUNT-1:0] eligible;

  xferGeom #(
    .OFS_W(OFS_W), .PITCH_W(PITCH_W), .DIM_W(DIM_W), .CRD_W(CRD_W),
    .DEPTH_W(DEPTH_W), .BPP_W(BPP_W), .ALIGN_LOG2(ALIGN_LOG2),
    .SRC_DIM_MAX(SRC_DIM_MAX), .DST_DIM_MAX(DST_DIM_MAX),
    .MIN_DIM(MIN_DIM), .MAX_BPP(MAX_BPP)
  ) i_geom (
    .srcPitch(srcPitch), .srcWidth(srcWidth), .srcHeight(srcHeight),
    .srcDepth(srcDepth), .srcBpp(srcBpp),
    .srcX0(srcX0), .srcX1(srcX1), .srcY0(srcY0), .srcY1(srcY1),
    .dstOffset(dstOffset), .dstPitch(dstPitch), .dstWidth(dstWidth),
    .dstHeight(dstHeight), .dstDepth(dstDepth), .dstBpp(dstBpp),
    .dstX0(dstX0), .dstX1(dstX1), .dstY0(dstY0), .dstY1(dstY1),
    .dstInVram(dstInVram), .flags(flags)
  );

  xferElig i_elig (
    .flags(flags), .hasNewEngine(hasNewEngine), .eligible(eligible)
  );

  xferPick i_pick (
    .eligible(eligible), .methodSel(methodSel), .noMethod(noMethod)
  );

  assign isScaled = flags.scaled;

  always_comb begin
    assert_pitched_unscaled_R3: assert (!(isScaled && methodSel[M_PITCHED]))
      else $error("pitched copy picked for a scaled move");
    assert_scaler_aligned_R5: assert (!methodSel[M_SCALER] || (dstOffset[ALIGN_LOG2-1:0] == '0))
      else $error("scaler picked with misaligned destination");
    assert_blit_engine_R8: assert (hasNewEngine || !methodSel[M_BLIT3D])
      else $error("3D blit picked without the new engine");
    assert_blit_bpp_R9: assert (!methodSel[M_BLIT3D] || ((srcBpp <= BPP_LIM) && (dstBpp <= BPP_LIM)))
      else $error("3D blit picked with oversized pixels");
  end

endmodule

// File: tb/test_xferPathSelect.sv
module test_xferPathSelect;

  localparam time CLK_PERIOD = 10ns;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic [15:0] srcPitch = '0, srcWidth = '0, srcHeight = '0;
  logic [11:0] srcDepth = '0;
  logic [2:0]  srcBpp = '0;
  logic [15:0] srcX0 = '0, srcX1 = '0, srcY0 = '0, srcY1 = '0;
  logic [31:0] dstOffset = '0;
  logic [15:0] dstPitch = '0, dstWidth = '0, dstHeight = '0;
  logic [11:0] dstDepth = '0;
  logic [2:0]  dstBpp = '0;
  logic [15:0] dstX0 = '0, dstX1 = '0, dstY0 = '0, dstY1 = '0;
  logic        dstInVram = 1'b0, hasNewEngine = 1'b0;
  logic [3:0]  methodSel;
  logic        noMethod, isScaled;

  xferPathSelect i_xferPathSelect (
    .srcPitch(srcPitch), .srcWidth(srcWidth), .srcHeight(srcHeight),
    .srcDepth(srcDepth), .srcBpp(srcBpp),
    .srcX0(srcX0), .srcX1(srcX1), .srcY0(srcY0), .srcY1(srcY1),
    .dstOffset(dstOffset), .dstPitch(dstPitch), .dstWidth(dstWidth),
    .dstHeight(dstHeight), .dstDepth(dstDepth), .dstBpp(dstBpp),
    .dstX0(dstX0), .dstX1(dstX1), .dstY0(dstY0), .dstY1(dstY1),
    .dstInVram(dstInVram), .hasNewEngine(hasNewEngine),
    .methodSel(methodSel), .noMethod(noMethod), .isScaled(isScaled)
  );

  typedef struct {
    logic [3:0] sel;
    logic       scaled;
    string      tag;
  } expItem_t;

  expItem_t expQ[$];
  expItem_t cur;
  int nChecks = 0;
  int nFails  = 0;
  bit allDone = 0;

  // Expected select encodings: bit0 pitched, bit1 scaler, bit2 3D blit, bit3 per-pixel
  localparam logic [3:0] SEL_PITCHED = 4'b0001;
  localparam logic [3:0] SEL_SCALER  = 4'b0010;
  localparam logic [3:0] SEL_BLIT    = 4'b0100;
  localparam logic [3:0] SEL_PIXEL   = 4'b1000;
  localparam logic [3:0] SEL_NONE    = 4'b0000;

  task automatic setBase();
    srcPitch = 16'd256; srcWidth = 16'd64; srcHeight = 16'd64;
    srcDepth = 12'd1; srcBpp = 3'd4;
    srcX0 = 16'd0; srcX1 = 16'd16; srcY0 = 16'd0; srcY1 = 16'd16;
    dstOffset = 32'd0; dstPitch = 16'd256; dstWidth = 16'd64; dstHeight = 16'd64;
    dstDepth = 12'd1; dstBpp = 3'd4;
    dstX0 = 16'd0; dstX1 = 16'd16; dstY0 = 16'd0; dstY1 = 16'd16;
    dstInVram = 1'b1; hasNewEngine = 1'b1;
  endtask

  // Driver: inputs settle just after a rising edge, expectation is queued
  task automatic pushVec(input logic [3:0] expSel, input logic expScaled, input string tag);
    expItem_t it;
    it.sel = expSel; it.scaled = expScaled; it.tag = tag;
    expQ.push_back(it);
  endtask

  task automatic waitEdge();
    @(posedge clk);
    #1;
  endtask

  // Monitor: compares at the falling edge
  always @(negedge clk) begin
    if (expQ.size() != 0) begin
      cur = expQ.pop_front();
      nChecks++;
      if (methodSel !== cur.sel || noMethod !== (cur.sel == 4'b0) || isScaled !== cur.scaled) begin
        nFails++;
        $display("FAIL %s: sel=%b noMethod=%b scaled=%b, expected sel=%b noMethod=%b scaled=%b",
                 cur.tag, methodSel, noMethod, isScaled, cur.sel, (cur.sel == 4'b0), cur.scaled);
      end
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // all-zero descriptors: equal zero spans, zero pitches, no engine -> per-pixel
    pushVec(SEL_PIXEL, 1'b0, "R10 reset-state zero descriptors");
    waitEdge();
    rst = 1'b0;

    setBase(); pushVec(SEL_PITCHED, 1'b0, "R3 R2 pitched unscaled base"); waitEdge();

    setBase(); srcX0 = 16'd5; srcX1 = 16'd21;
    pushVec(SEL_PITCHED, 1'b0, "R1 shifted corners same span"); waitEdge();

    setBase(); dstY1 = 16'd17;
    pushVec(SEL_SCALER, 1'b1, "R1 R4 Y span differs -> scaler"); waitEdge();

    setBase(); dstX1 = 16'd32;
    pushVec(SEL_SCALER, 1'b1, "R4 R7 scaled pitched vram dst"); waitEdge();

    setBase(); dstX1 = 16'd32; srcPitch = 16'd0;
    pushVec(SEL_BLIT, 1'b1, "R8 scaled, src swizzled -> blit"); waitEdge();

    setBase(); dstX1 = 16'd32; srcPitch = 16'd0; hasNewEngine = 1'b0;
    pushVec(SEL_NONE, 1'b1, "R11 R10 scaled with no engine"); waitEdge();

    setBase(); dstPitch = 16'd0;
    pushVec(SEL_SCALER, 1'b0, "R6 swizzled dst within limits"); waitEdge();

    setBase(); dstX1 = 16'd32; srcWidth = 16'd1024; srcHeight = 16'd512;
    pushVec(SEL_BLIT, 1'b1, "R4 OR limit 1024|512 rejected"); waitEdge();

    setBase(); dstX1 = 16'd32; srcWidth = 16'd1024; srcHeight = 16'd1024;
    pushVec(SEL_SCALER, 1'b1, "R4 OR limit 1024|1024 accepted"); waitEdge();

    setBase(); dstX1 = 16'd32; srcWidth = 16'd1;
    pushVec(SEL_BLIT, 1'b1, "R4 source width below 2"); waitEdge();

    setBase(); dstX1 = 16'd32; srcDepth = 12'd2;
    pushVec(SEL_BLIT, 1'b1, "R4 source depth 2"); waitEdge();

    setBase(); dstX1 = 16'd32; dstOffset = 32'd32;
    pushVec(SEL_NONE, 1'b1, "R5 dst offset 32 misaligned"); waitEdge();

    setBase(); dstX1 = 16'd32; dstOffset = 32'd64;
    pushVec(SEL_SCALER, 1'b1, "R5 dst offset 64 aligned"); waitEdge();

    setBase(); dstX1 = 16'd32; dstInVram = 1'b0;
    pushVec(SEL_BLIT, 1'b1, "R7 dst outside video memory"); waitEdge();

    setBase(); dstX1 = 16'd32; dstPitch = 16'd96;
    pushVec(SEL_NONE, 1'b1, "R7 dst pitch 96 misaligned"); waitEdge();

    setBase(); dstX1 = 16'd32; dstPitch = 16'd0; dstWidth = 16'd4096; dstHeight = 16'd2;
    pushVec(SEL_BLIT, 1'b1, "R6 swizzled dst OR 4096|2 too big"); waitEdge();

    setBase(); dstX1 = 16'd32; srcPitch = 16'd0; dstPitch = 16'd0; dstBpp = 3'd1;
    pushVec(SEL_NONE, 1'b1, "R9 byte dst swizzled rejects blit"); waitEdge();

    setBase(); dstX1 = 16'd32; srcPitch = 16'd0; dstBpp = 3'd1;
    pushVec(SEL_BLIT, 1'b1, "R9 byte dst pitched keeps blit"); waitEdge();

    setBase(); dstX1 = 16'd32; srcPitch = 16'd0; srcBpp = 3'd5;
    pushVec(SEL_NONE, 1'b1, "R9 source bpp 5"); waitEdge();

    setBase(); dstX1 = 16'd32; srcPitch = 16'd0; dstDepth = 12'd2;
    pushVec(SEL_NONE, 1'b1, "R8 dst depth 2"); waitEdge();

    setBase(); dstX1 = 16'd32; srcPitch = 16'd0; dstHeight = 16'd1;
    pushVec(SEL_NONE, 1'b1, "R8 dst height 1"); waitEdge();

    setBase(); srcPitch = 16'd0; srcDepth = 12'd2;
    pushVec(SEL_BLIT, 1'b0, "R2 unscaled, blit ahead of per-pixel"); waitEdge();

    setBase(); srcPitch = 16'd0; srcDepth = 12'd2; hasNewEngine = 1'b0;
    pushVec(SEL_PIXEL, 1'b0, "R10 per-pixel fallback"); waitEdge();

    waitEdge();
    waitEdge();
    allDone = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!allDone) begin
      nFails++;
      $display("FAIL watchdog R2: run did not complete, expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

endmodule